// File: doc/BRIEF.md
# Issue Scoreboard with Unit Tracking

This block sits between instruction decode and a group of independent multi-cycle execution units. Every cycle it looks at the decoded instruction and decides whether it may issue. It returns one of two answers: issue, together with a one-hot start strobe to the chosen unit, or stall. The stall answer freezes the decode stage.

It holds two pieces of state:
- A set of destination registers whose results are still outstanding.
- A busy flag for each execution unit. There are two multipliers and two dividers.

Both source addresses are compared against the outstanding set at the same time. An instruction issues only when neither source is outstanding and a unit of the required kind is free. Within each pair the block alternates between the two units. Units capture their operands on the start strobe, so the issue side holds nothing after dispatch.

Each unit reports completion with a one-cycle pulse that carries the destination it wrote. That pulse frees the unit and the register.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset, no register is outstanding and every unit is free. With `dec_valid` low, `issue`, `stall` and `unit_start` are all zero.
- R2: When `dec_valid` is high and either `dec_src_a` or `dec_src_b` names an outstanding register, `stall` is 1, `issue` is 0 and `unit_start` is zero. This happens in the same cycle.
- R3: A completion pulse `done_vld[i]` frees the register in `done_dst[4*i+3:4*i]`. In the cycle of the pulse that register still counts as outstanding. From the next cycle on, neither source channel reports a conflict on it.
- R4: A multiply or divide that issues with `dec_has_dst` = 1 marks `dec_dst` outstanding from the next cycle. With `dec_has_dst` = 0 it marks nothing. ALU operations never mark a register.
- R5: If a completion frees register r in the same cycle that an issue marks r, then r is outstanding in the next cycle.
- R6: A unit is busy from the edge that starts it until the edge of its completion pulse. While both units of the requested pair are busy, a multiply or divide stalls even when there is no operand conflict.
- R7: Operation codes are 0 = ALU, 1 = multiply, 2 = divide and 3 = ALU. Multiply uses units 0 and 1, and divide uses units 2 and 3. After one unit of a pair starts, the next request of that kind goes to the other unit if it is free. If only one unit of the pair is free, that unit is chosen. After reset each pair prefers its lower unit.
- R8: An ALU operation issues whenever neither source is outstanding, whatever the busy state of the units. It raises no `unit_start` bit.
- R9: When `dec_valid` is high, exactly one of `issue` and `stall` is 1. When it is low, both are 0. `unit_start` has at most one bit set, and a bit is set only for an issued multiply or divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_op | input | 2 | Operation class: 0 ALU, 1 multiply, 2 divide, 3 ALU |
| dec_src_a | input | 4 | First source register |
| dec_src_b | input | 4 | Second source register |
| dec_dst | input | 4 | Destination register |
| dec_has_dst | input | 1 | Instruction writes a destination |
| done_vld | input | 4 | Per-unit completion pulse |
| done_dst | input | 16 | Destination written by each unit, unit i in bits 4i+3..4i |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |
| unit_start | output | 4 | One-hot start strobe to the chosen unit |

## Verification
On every cycle, assertions check the following:
- No instruction issues with an outstanding source.
- A start never goes to a busy unit, and `unit_start` stays one-hot or zero.
- A started unit reads busy on the next cycle.
- A register marked in the same cycle as it is freed stays outstanding.
- `issue` and `stall` are mutually exclusive.

Some behaviour only the directed scenarios can show:
- The alternation order within each pair.
- The one-cycle delay before a completion takes effect.
- ALU operations going past busy units.
- No register being marked by ALU operations or by instructions without a destination.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int unsigned RADDR_W = 4;
  localparam int unsigned PAIRS   = 2;

  typedef enum logic [1:0] {
    OPC_ALU  = 2'd0,
    OPC_MUL  = 2'd1,
    OPC_DIV  = 2'd2,
    OPC_ALU2 = 2'd3
  } opc_e;
endpackage

// File: rtl/isb_pending.sv
module isb_pending #(
  parameter int unsigned RW    = 4,
  parameter int unsigned NUNIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RW-1:0]       src_a,
  input  logic [RW-1:0]       src_b,
  input  logic                issue_i,
  input  logic                mark_en,
  input  logic [RW-1:0]       mark_addr,
  input  logic [NUNIT-1:0]    wb_vld,
  input  logic [NUNIT*RW-1:0] wb_dst,
  output logic                conflict
);
  localparam int unsigned NREG = 1 << RW;

  logic [NREG-1:0] outst_q, outst_d, free_v, mark_v;

  always_comb begin
    free_v = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (wb_vld[u]) free_v[wb_dst[u*RW +: RW]] = 1'b1;
    end
    mark_v = '0;
    if (mark_en) mark_v[mark_addr] = 1'b1;
    outst_d  = (outst_q & ~free_v) | mark_v;
    conflict = outst_q[src_a] | outst_q[src_b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= outst_d;
  end

  AST_NO_ISSUE_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !(outst_q[src_a] || outst_q[src_b])); // R2

  AST_MARK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && free_v[mark_addr]) |=> outst_q[$past(mark_addr)]); // R5

  AST_FREE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(free_v & ~mark_v)) |=> ((outst_q & $past(free_v & ~mark_v)) == '0)); // R3
endmodule

// File: rtl/isb_unit_pool.sv
module isb_unit_pool #(
  parameter int unsigned NPAIR = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_unit,
  input  logic [PW-1:0]             req_pair,
  input  logic                      go_i,
  input  logic [2*NPAIR-1:0]        done_vld,
  output logic                      avail,
  output logic [2*NPAIR-1:0]        start
);
  localparam int unsigned NUNIT = 2 * NPAIR;
  localparam int unsigned PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [NUNIT-1:0] busy_q, busy_d;
  logic [NPAIR-1:0] pref_q, pref_d, pair_av;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic lo_free, hi_free, pick_hi, hit;
    assign lo_free    = ~busy_q[2*p];
    assign hi_free    = ~busy_q[2*p+1];
    assign pick_hi    = pref_q[p] ? hi_free : ~lo_free;
    assign pair_av[p] = lo_free | hi_free;
    assign hit        = go_i & req_unit & (req_pair == PW'(p));
    assign start[2*p]   = hit & ~pick_hi;
    assign start[2*p+1] = hit & pick_hi;
    assign pref_d[p]  = hit ? ~pick_hi : pref_q[p];
  end

  assign avail  = pair_av[req_pair];
  assign busy_d = (busy_q & ~done_vld) | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      pref_q <= '0;
    end else begin
      busy_q <= busy_d;
      pref_q <= pref_d;
    end
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start)); // R9

  AST_START_IDLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start & busy_q) == '0); // R6

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|start) |=> ((busy_q & $past(start)) == $past(start))); // R6
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import isb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [1:0]               dec_op,
  input  logic [RADDR_W-1:0]       dec_src_a,
  input  logic [RADDR_W-1:0]       dec_src_b,
  input  logic [RADDR_W-1:0]       dec_dst,
  input  logic                     dec_has_dst,
  input  logic [2*PAIRS-1:0]       done_vld,
  input  logic [2*PAIRS*RADDR_W-1:0] done_dst,
  output logic                     issue,
  output logic                     stall,
  output logic [2*PAIRS-1:0]       unit_start
);
  localparam int unsigned NUNIT = 2 * PAIRS;
  localparam int unsigned PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic          is_mul, is_div, is_unit, conflict, avail, mark_en;
  logic [PW-1:0] pair_sel;

  assign is_mul   = (opc_e'(dec_op) == OPC_MUL);
  assign is_div   = (opc_e'(dec_op) == OPC_DIV);
  assign is_unit  = is_mul | is_div;
  assign pair_sel = is_div ? PW'(1) : PW'(0);

  assign issue   = dec_valid & ~conflict & (~is_unit | avail);
  assign stall   = dec_valid & ~issue;
  assign mark_en = issue & is_unit & dec_has_dst;

  isb_pending #(.RW(RADDR_W), .NUNIT(NUNIT)) i_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a     (dec_src_a),
    .src_b     (dec_src_b),
    .issue_i   (issue),
    .mark_en   (mark_en),
    .mark_addr (dec_dst),
    .wb_vld    (done_vld),
    .wb_dst    (done_dst),
    .conflict  (conflict)
  );

  isb_unit_pool #(.NPAIR(PAIRS)) i_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_unit (is_unit),
    .req_pair (pair_sel),
    .go_i     (issue),
    .done_vld (done_vld),
    .avail    (avail),
    .start    (unit_start)
  );

  AST_ISSUE_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid ? (issue != stall) : (!issue && !stall)); // R9

  AST_ALU_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_unit || !issue) |-> (unit_start == '0)); // R8
endmodule

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_has_dst;
  logic [1:0]  dec_op;
  logic [3:0]  dec_src_a, dec_src_b, dec_dst, done_vld, unit_start;
  logic [15:0] done_dst;
  logic        issue, stall;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  issue_scoreboard i_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .dec_has_dst(dec_has_dst), .done_vld(done_vld), .done_dst(done_dst),
    .issue(issue), .stall(stall), .unit_start(unit_start)
  );

  function automatic logic [15:0] wb(input int u, input logic [3:0] r);
    return {12'b0, r} << (4*u);
  endfunction

  task automatic drive(input logic v, input logic [1:0] op, input logic [3:0] sa,
                       input logic [3:0] sb, input logic [3:0] d, input logic hd,
                       input logic [3:0] dv, input logic [15:0] dd);
    @(negedge clk);
    dec_valid = v; dec_op = op; dec_src_a = sa; dec_src_b = sb;
    dec_dst = d; dec_has_dst = hd; done_vld = dv; done_dst = dd;
    #1;
  endtask

  task automatic expect_out(input string req, input logic ei, input logic es,
                            input logic [3:0] est);
    n_chk++;
    if (issue !== ei || stall !== es || unit_start !== est) begin
      n_bad++;
      $display("FAIL %s: issue=%b stall=%b start=%b expected issue=%b stall=%b start=%b",
               req, issue, stall, unit_start, ei, es, est);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    drive(1'b0, 2'd1, 4'd1, 4'd2, 4'd3, 1'b1, 4'd0, 16'd0);
    expect_out("R1 idle", 1'b0, 1'b0, 4'b0000);
    drive(1'b1, 2'd0, 4'd5, 4'd6, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R1 alu after reset", 1'b1, 1'b0, 4'b0000);
    drive(1'b1, 2'd3, 4'd0, 4'd15, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R8 opcode 3 as alu", 1'b1, 1'b0, 4'b0000);
  endtask

  task automatic t_hazard_clear();
    do_reset();
    drive(1'b1, 2'd1, 4'd1, 4'd2, 4'd3, 1'b1, 4'd0, 16'd0);
    expect_out("R7 first mul unit0", 1'b1, 1'b0, 4'b0001);
    drive(1'b1, 2'd0, 4'd3, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R2 conflict on src a", 1'b0, 1'b1, 4'b0000);
    drive(1'b1, 2'd2, 4'd0, 4'd3, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R2 conflict on src b", 1'b0, 1'b1, 4'b0000);
    drive(1'b1, 2'd0, 4'd4, 4'd4, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R8 alu no conflict", 1'b1, 1'b0, 4'b0000);
    drive(1'b1, 2'd0, 4'd3, 4'd0, 4'd0, 1'b0, 4'b0001, wb(0, 4'd3));
    expect_out("R3 still pending in pulse cycle", 1'b0, 1'b1, 4'b0000);
    drive(1'b1, 2'd0, 4'd0, 4'd3, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R3 freed next cycle", 1'b1, 1'b0, 4'b0000);
    drive(1'b1, 2'd1, 4'd0, 4'd0, 4'd7, 1'b0, 4'd0, 16'd0);
    expect_out("R7 mul alternates to unit1", 1'b1, 1'b0, 4'b0010);
    drive(1'b1, 2'd0, 4'd7, 4'd7, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R4 no-dst marks nothing", 1'b1, 1'b0, 4'b0000);
  endtask

  task automatic t_units();
    do_reset();
    drive(1'b1, 2'd2, 4'd0, 4'd0, 4'd1, 1'b1, 4'd0, 16'd0);
    expect_out("R7 div unit2", 1'b1, 1'b0, 4'b0100);
    drive(1'b1, 2'd2, 4'd0, 4'd0, 4'd2, 1'b1, 4'd0, 16'd0);
    expect_out("R7 div unit3", 1'b1, 1'b0, 4'b1000);
    drive(1'b1, 2'd2, 4'd0, 4'd0, 4'd3, 1'b1, 4'd0, 16'd0);
    expect_out("R6 both dividers busy", 1'b0, 1'b1, 4'b0000);
    drive(1'b1, 2'd0, 4'd9, 4'd9, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R8 alu past busy units", 1'b1, 1'b0, 4'b0000);
    drive(1'b1, 2'd2, 4'd0, 4'd0, 4'd3, 1'b1, 4'b1000, wb(3, 4'd2));
    expect_out("R6 busy through pulse cycle", 1'b0, 1'b1, 4'b0000);
    drive(1'b1, 2'd2, 4'd0, 4'd0, 4'd3, 1'b1, 4'd0, 16'd0);
    expect_out("R7 only free unit3 chosen", 1'b1, 1'b0, 4'b1000);
    drive(1'b1, 2'd1, 4'd0, 4'd0, 4'd5, 1'b1, 4'd0, 16'd0);
    expect_out("R6 mul pair independent", 1'b1, 1'b0, 4'b0001);
  endtask

  task automatic t_same_cycle();
    do_reset();
    drive(1'b1, 2'd1, 4'd0, 4'd0, 4'd4, 1'b1, 4'd0, 16'd0);
    expect_out("R4 mul marks r4", 1'b1, 1'b0, 4'b0001);
    drive(1'b1, 2'd2, 4'd0, 4'd1, 4'd4, 1'b1, 4'b0001, wb(0, 4'd4));
    expect_out("R5 div marks r4 while freed", 1'b1, 1'b0, 4'b0100);
    drive(1'b1, 2'd0, 4'd4, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R5 r4 stays pending", 1'b0, 1'b1, 4'b0000);
    drive(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 1'b0, 4'b0100, wb(2, 4'd4));
    expect_out("R9 idle no outputs", 1'b0, 1'b0, 4'b0000);
    drive(1'b1, 2'd0, 4'd4, 4'd4, 4'd8, 1'b1, 4'd0, 16'd0);
    expect_out("R3 r4 freed", 1'b1, 1'b0, 4'b0000);
    drive(1'b1, 2'd0, 4'd8, 4'd0, 4'd0, 1'b0, 4'd0, 16'd0);
    expect_out("R4 alu dst not marked", 1'b1, 1'b0, 4'b0000);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hazard_clear();
    t_units();
    t_same_cycle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule